// File: doc/BRIEF.md
# Ring-Counter Control Word Sequencer

This block is the control unit of a small single-bus accumulator machine. A six-bit ring counter walks one hot bit through timing states t1 to t6. States t1 to t3 fetch an instruction, and states t4 to t6 execute it. In every state the block combines the current state with the 4-bit opcode to form a 12-bit control word. That word drives the datapath's register loads, its bus drivers, the program-counter increment and the add/subtract select.

The datapath registers sit outside this block. The host datapath applies the opcode from its instruction register and connects each control bit to the matching strobe. The opcode is expected to be valid from t4 onward. A halt opcode freezes the sequencer until the asynchronous clear is asserted.

Top module: `ctrl_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is `6'b000001` (t1) and `ctrl_o` is `12'h5E3`. The clear acts without waiting for a clock edge.
- R2: `state_o` is always one-hot, with bit k standing for state t(k+1). Each clock moves it from t1 through t6, and after t6 it returns to t1 unless the sequencer is halted.
- R3: Control bit order from bit 11 down to bit 0 is: PC increment, PC drive, address load (low), memory drive (low), instruction load (low), operand-field drive (low), accumulator load (low), accumulator drive, subtract select, ALU drive, B load (low), output load (low). The fetch words are fixed whatever the opcode: t1 = `12'h5E3`, t2 = `12'hBE3`, t3 = `12'h263`.
- R4: Opcode `4'h0` (load accumulator) gives t4 = `12'h1A3`, t5 = `12'h2C3` and t6 = `12'h3E3`.
- R5: Opcode `4'h1` (add) gives t4 = `12'h1A3`, t5 = `12'h2E1` and t6 = `12'h3C7`.
- R6: Opcode `4'h2` (subtract) gives t4 = `12'h1A3`, t5 = `12'h2E1` and t6 = `12'h3CF`. This is the add sequence with the subtract select also asserted in t6.
- R7: Opcode `4'hE` (output) gives t4 = `12'h3F2`, and t5 and t6 both give the idle word `12'h3E3`.
- R8: Opcodes `4'h3` to `4'hD` run as no-ops: `12'h3E3` in t4, t5 and t6, and the ring keeps advancing.
- R9: Opcode `4'hF` (halt) seen in t4 gives `12'h3E3` in that cycle. The ring then stays at t4 and `ctrl_o` stays at `12'h3E3` whatever the opcode does, until `rst_ni` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the ring advances on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear; returns to t1 and leaves the halt |
| op_i | input | 4 | Opcode from the instruction register |
| ctrl_o | output | 12 | Control word, mixed polarity, ordered as in R3 |
| state_o | output | 6 | One-hot timing state, bit 0 = t1 |

## Verification
In t4, decoding the execute word and detecting a halt fall in the same cycle. The halt decision also competes with the ring's normal advance at the same clock edge. The bench drives opcode `4'hF` into t4 after runs of ordinary instructions. It then keeps changing the opcode, including back to valid instructions, and requires the state to stay at t4 with the idle word on every cycle. A clear applied while halted must win over the frozen state. A reference model in the bench, built only on state numbers and a halt flag, predicts both outputs on every cycle, including random opcode changes during fetch.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int unsigned NUM_T = 6;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned CW_W  = 12;

  typedef logic [CW_W-1:0] cword_t;

  // control bit positions, MSB first
  localparam int unsigned B_PC_INC = 11;
  localparam int unsigned B_PC_DRV = 10;
  localparam int unsigned B_ADR_LD = 9;
  localparam int unsigned B_MEM_DRV = 8;
  localparam int unsigned B_IR_LD  = 7;
  localparam int unsigned B_IR_DRV = 6;
  localparam int unsigned B_ACC_LD = 5;
  localparam int unsigned B_ACC_DRV = 4;
  localparam int unsigned B_SUB    = 3;
  localparam int unsigned B_ALU_DRV = 2;
  localparam int unsigned B_B_LD   = 1;
  localparam int unsigned B_OUT_LD = 0;

  // inactive levels: active-low bits sit at 1
  localparam cword_t IDLE_WORD = cword_t'((1 << B_ADR_LD) | (1 << B_MEM_DRV) | (1 << B_IR_LD)
                                 | (1 << B_IR_DRV) | (1 << B_ACC_LD) | (1 << B_B_LD)
                                 | (1 << B_OUT_LD));

  localparam logic [OP_W-1:0] OP_LOAD = 4'h0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OP_SHOW = 4'hE;
  localparam logic [OP_W-1:0] OP_STOP = 4'hF;

  function automatic cword_t assert_bits(input int unsigned a, input int unsigned b);
    cword_t m;
    m = '0;
    if (a < CW_W) m[a] = 1'b1;
    if (b < CW_W) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ctrl_seq_ring.sv
module ctrl_seq_ring #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  output logic [N-1:0] ring_o
);
  logic [N-1:0] ring_q, ring_d;

  assign ring_d[0] = ring_q[N-1];
  for (genvar i = 1; i < N; i++) begin : g_shift
    assign ring_d[i] = ring_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ring_q <= {{(N-1){1'b0}}, 1'b1};
    else if (!hold_i) ring_q <= ring_d;
  end

  assign ring_o = ring_q;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) == 1);
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_q[N-1] && !hold_i) |=> ring_q[0]);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(ring_q));
endmodule

// File: rtl/ctrl_seq_decode.sv
module ctrl_seq_decode
  import ctrl_seq_pkg::*;
(
  input  logic [NUM_T-1:0] ring_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             halt_i,
  output cword_t           cw_o
);
  localparam int unsigned NONE = CW_W;
  cword_t act;

  always_comb begin
    act = '0;
    if (ring_i[0])      act = assert_bits(B_PC_DRV, B_ADR_LD);
    else if (ring_i[1]) act = assert_bits(B_PC_INC, NONE);
    else if (ring_i[2]) act = assert_bits(B_MEM_DRV, B_IR_LD);
    else if (!halt_i) begin
      unique case (op_i)
        OP_LOAD: begin
          if (ring_i[3]) act = assert_bits(B_ADR_LD, B_IR_DRV);
          if (ring_i[4]) act = assert_bits(B_MEM_DRV, B_ACC_LD);
        end
        OP_ADD, OP_SUB: begin
          if (ring_i[3]) act = assert_bits(B_ADR_LD, B_IR_DRV);
          if (ring_i[4]) act = assert_bits(B_MEM_DRV, B_B_LD);
          if (ring_i[5]) act = assert_bits(B_ACC_LD, B_ALU_DRV)
                               | assert_bits((op_i == OP_SUB) ? B_SUB : NONE, NONE);
        end
        OP_SHOW: begin
          if (ring_i[3]) act = assert_bits(B_ACC_DRV, B_OUT_LD);
        end
        default: act = '0;
      endcase
    end
    cw_o = IDLE_WORD ^ act;
  end
endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  op_i,
  output logic [11:0] ctrl_o,
  output logic [5:0]  state_o
);
  logic [NUM_T-1:0] ring;
  logic             halted_q, halt_now, hold;

  assign halt_now = ring[3] && (op_i == OP_STOP);
  assign hold     = halted_q || halt_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       halted_q <= 1'b0;
    else if (halt_now) halted_q <= 1'b1;
  end

  ctrl_seq_ring #(.N(NUM_T)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .ring_o(ring)
  );

  ctrl_seq_decode u_dec (
    .ring_i(ring),
    .op_i  (op_i),
    .halt_i(halted_q),
    .cw_o  (ctrl_o)
  );

  assign state_o = ring;

  assert_halt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> (ctrl_o == IDLE_WORD));
  assert_halt_t4_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> state_o[3]);
  assert_fetch_t1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[0] |-> (ctrl_o == 12'h5E3));
  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q);
endmodule

// File: tb/ctrl_seq_test.sv
module ctrl_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [11:0] ctrl;
  logic [5:0]  state;

  int checks = 0;
  int errors = 0;
  int m_st = 1;
  bit m_halt = 1'b0;

  always #10 clk = ~clk;

  ctrl_seq uut (.clk_i(clk), .rst_ni(rst_ni), .op_i(op), .ctrl_o(ctrl), .state_o(state));

  function automatic logic [11:0] exp_word(int st, logic [3:0] o, bit h);
    if (st == 1) return 12'h5E3;
    if (st == 2) return 12'hBE3;
    if (st == 3) return 12'h263;
    if (h) return 12'h3E3;
    case (o)
      4'h0: return (st == 4) ? 12'h1A3 : (st == 5) ? 12'h2C3 : 12'h3E3;
      4'h1: return (st == 4) ? 12'h1A3 : (st == 5) ? 12'h2E1 : 12'h3C7;
      4'h2: return (st == 4) ? 12'h1A3 : (st == 5) ? 12'h2E1 : 12'h3CF;
      4'hE: return (st == 4) ? 12'h3F2 : 12'h3E3;
      default: return 12'h3E3;
    endcase
  endfunction

  function automatic string tag(int st, logic [3:0] o, bit h);
    if (st <= 3) return "R3";
    if (h || (st == 4 && o == 4'hF)) return "R9";
    case (o)
      4'h0: return "R4";
      4'h1: return "R5";
      4'h2: return "R6";
      4'hE: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_now(string st_tag, string cw_tag);
    logic [5:0]  es;
    logic [11:0] ew;
    es = 6'b1 << (m_st - 1);
    ew = exp_word(m_st, op, m_halt);
    checks++;
    if (state !== es) begin
      errors++;
      $display("FAIL %s state: actual %b expected %b", st_tag, state, es);
    end
    checks++;
    if (ctrl !== ew) begin
      errors++;
      $display("FAIL %s ctrl (t%0d op %h): actual %h expected %h", cw_tag, m_st, op, ctrl, ew);
    end
  endtask

  task automatic advance();
    if (m_halt) return;
    if (m_st == 4 && op == 4'hF) m_halt = 1'b1;
    else m_st = (m_st == 6) ? 1 : m_st + 1;
  endtask

  task automatic run_cycle(logic [3:0] o);
    @(negedge clk);
    op = o;
    #1;
    check_now(m_halt ? "R9" : "R2", tag(m_st, op, m_halt));
    advance();
  endtask

  task automatic do_reset(logic [3:0] o);
    @(negedge clk);
    rst_ni = 1'b0;
    op = o;
    m_st = 1;
    m_halt = 1'b0;
    #1;
    check_now("R1", "R1");
    @(negedge clk);
    op = o ^ 4'h5;
    #1;
    check_now("R1", "R1");
    rst_ni = 1'b1;
    advance();
  endtask

  task automatic align();
    while (m_st != 1) run_cycle(4'h0);
  endtask

  task automatic instr(logic [3:0] o);
    for (int i = 0; i < 6; i++) run_cycle(o);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] prog [9] = '{4'h0, 4'h1, 4'h2, 4'hE, 4'h3, 4'h7, 4'hD, 4'h0, 4'hC};
    do_reset(4'hF);
    align();
    foreach (prog[i]) instr(prog[i]);
    // opcode noise during fetch (R3), then a subtract
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 3; i++) run_cycle(4'($urandom));
      for (int i = 0; i < 3; i++) run_cycle(4'h2);
    end
    for (int i = 0; i < 60; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 14));
      run_cycle(r);
    end
    // halt in t4, then opcode changes must be ignored (R9)
    align();
    instr(4'h1);
    for (int i = 0; i < 3; i++) run_cycle(4'h0);
    run_cycle(4'hF);
    for (int i = 0; i < 10; i++) run_cycle((i % 2) ? 4'h1 : 4'($urandom));
    // clear while halted (R1)
    do_reset(4'h2);
    align();
    instr(4'h0);
    instr(4'h2);
    instr(4'hE);
    for (int i = 0; i < 120; i++) run_cycle(4'($urandom));
    do_reset(4'h0);
    for (int i = 0; i < 8; i++) run_cycle(4'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule